// File: doc/BRIEF.md
# Video Controller Host Register Port

This block is the processor-side register window of a tile-based video display controller. A host drives a 2-bit offset, a byte of write data and single-cycle read or write strobes. Writing offset 0 chooses which internal 16-bit register the two data offsets reach. Each data byte lands in its own lane of that register. Reading offset 0 returns the event status byte and clears it. The read data bus is combinational from the current offset and the block's state, and every side effect takes place on the clock edge that ends the access.

Video memory holds 32K words of 16 bits and is reached only through two address registers that step on their own. A word is written to memory when the host writes the high byte of the memory-data register. Words are read through a prefetch buffer: the buffer is refilled when the read address is loaded or advanced. Advancing happens on the high-byte read of the memory-data register. The step size is chosen by two control bits. Six single-cycle event inputs set status bits. An interrupt output is raised while any set status bit is also enabled in the control register.

Top module: `vid_host_port`

## Requirements
- R1: Only the two offset bits are decoded. A write to offset 0 loads bits 4:0 of the byte into the select latch. Offsets 2 and 3 reach the low and high byte of the selected register, and a write to offset 1 has no effect. Select codes: 0 = memory write address, 1 = memory read address, 2 = memory data, 5 = control.
- R2: A low-byte write changes only bits 7:0 of the selected register, and a high-byte write changes only bits 15:8.
- R3: A read of offset 0 returns the status byte, with event bits in 5:0 and zeros in 7:6, and then clears bits 5:0. An event arriving in the same cycle as that read is not in the returned byte but stays set afterwards.
- R4: `irqOut` is high exactly while some status bit i (0..5) is set and control bit i is set. It drops after a clearing status read when no new enabled event arrives.
- R5: A read of offset 2 or 3 returns the low or high byte of the read buffer, never memory directly.
- R6: With select 2, a high-byte read adds the stride to the read address and issues a memory read at the new address. A low-byte read moves nothing.
- R7: The stride is taken from control bits 12:11: 00 gives 1, 01 gives 32, 10 gives 64, and 11 gives 128.
- R8: The address registers are 16 bits and wrap modulo 65536. Memory sees only their low 15 bits.
- R9: A read of offset 1 returns 0x40 when `dotClkSel` is nonzero, and 0x00 otherwise.
- R10: With select 1, a high-byte write completes the read address and issues a memory read at that address to refill the buffer.
- R11: With select 2, a high-byte write stores {that byte, last low byte written to select 2} at the write address, then adds the stride to the write address. A memory write and a memory read are never issued in the same cycle.
- R12: Memory answers one cycle after a read request. The buffer takes the new word on the second clock edge after the requesting access, so a data read in the cycle between returns the previous buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Host register offset |
| busWe | input | 1 | Host write strobe, one cycle per access |
| busRe | input | 1 | Host read strobe, one cycle per access |
| busWdata | input | 8 | Host write byte |
| busRdata | output | 8 | Host read byte for the current offset |
| evtIn | input | 6 | Single-cycle event pulses that set status bits |
| dotClkSel | input | 2 | Pixel clock setting; nonzero means a fast mode |
| irqOut | output | 1 | Interrupt request |
| vramAddr | output | 15 | Video memory word address |
| vramWe | output | 1 | Video memory write enable |
| vramWdata | output | 16 | Video memory write word |
| vramRe | output | 1 | Video memory read request |
| vramRdata | input | 16 | Video memory read word, valid the cycle after the request |

## Verification
The status register can be hit by a clearing read and a new event in the same cycle. The bench provokes this by holding an enabled event pulse high during the very cycle of an offset-0 read. It judges the result three ways: the returned byte must leave the new event out, the interrupt must stay high afterwards, and a second read must report only the new bit. The refill of the read buffer can also overlap a host data read. A high-byte read is followed at once by two low-byte reads: the first must see the old buffer and the second the word at the advanced address.

// File: rtl/vid_host_pkg.sv
package vid_host_pkg;

  localparam int REG_W = 16;
  localparam int SEL_W = 5;
  localparam int EVT_W = 6;
  localparam int BYTE_W = 8;

  localparam logic [SEL_W-1:0] SEL_WADDR = 5'd0;
  localparam logic [SEL_W-1:0] SEL_RADDR = 5'd1;
  localparam logic [SEL_W-1:0] SEL_DATA  = 5'd2;
  localparam logic [SEL_W-1:0] SEL_CTRL  = 5'd5;

  typedef enum logic [1:0] {
    OFS_STAT = 2'd0,
    OFS_AUX  = 2'd1,
    OFS_LO   = 2'd2,
    OFS_HI   = 2'd3
  } hostOfs_e;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic             laneLo;
    logic             laneHi;
    logic [SEL_W-1:0] target;
    logic             commitWr;
    logic             loadRd;
    logic             stepRd;
    logic             clrStat;
  } hostStb_t;

  // Step size: code 0 -> 1, codes 1..3 -> 1 << (code + 4).
  function automatic logic [REG_W-1:0] strideOf(input logic [1:0] code);
    logic [REG_W-1:0] one;
    one = 1;
    if (code == 2'd0) return one;
    return one << (32'(code) + 4);
  endfunction

endpackage

// File: rtl/vid_host_ctrl.sv
module vid_host_ctrl
  import vid_host_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWe,
  input  logic             busRe,
  input  logic [SEL_W-1:0] busSelByte,
  output hostStb_t         stb
);

  logic [SEL_W-1:0] selReg;
  logic             wrOk;
  logic             selLoad;

  // A read wins over a write presented in the same cycle.
  assign wrOk    = busWe & ~busRe;
  assign selLoad = wrOk & (busAddr == OFS_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= '0;
    end else if (selLoad) begin
      selReg <= busSelByte;
    end
  end

  always_comb begin
    stb          = '0;
    stb.target   = selReg;
    stb.laneLo   = wrOk & (busAddr == OFS_LO);
    stb.laneHi   = wrOk & (busAddr == OFS_HI);
    stb.commitWr = stb.laneHi & (selReg == SEL_DATA);
    stb.loadRd   = stb.laneHi & (selReg == SEL_RADDR);
    stb.stepRd   = busRe & (busAddr == OFS_HI) & (selReg == SEL_DATA);
    stb.clrStat  = busRe & (busAddr == OFS_STAT);
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !selLoad |=> $stable(selReg)); // R1

  AST_AUX_WRITE_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == OFS_AUX) |=> $stable(selReg)); // R1

endmodule

// File: rtl/vid_host_dp.sv
module vid_host_dp
  import vid_host_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStb_t          stb,
  input  logic [1:0]        busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic [1:0]        dotClkSel,
  output logic              irqOut,
  output logic [ADDR_W-1:0] vramAddr,
  output logic              vramWe,
  output logic [REG_W-1:0]  vramWdata,
  output logic              vramRe,
  input  logic [REG_W-1:0]  vramRdata
);

  localparam int PAD_W = BYTE_W - EVT_W;
  localparam logic [BYTE_W-1:0] AUX_FAST = 8'h40;

  logic [REG_W-1:0]  wAddr;
  logic [REG_W-1:0]  rAddr;
  logic [REG_W-1:0]  readBuf;
  logic [BYTE_W-1:0] dataLo;
  logic [EVT_W-1:0]  irqEn;
  logic [1:0]        strideCode;
  logic [EVT_W-1:0]  statBits;
  logic              rdPend;

  logic [REG_W-1:0]  stride;
  logic [REG_W-1:0]  rLoadVal;
  logic [REG_W-1:0]  rStepVal;

  assign stride   = strideOf(strideCode);
  assign rLoadVal = {busWdata, rAddr[7:0]};
  assign rStepVal = rAddr + stride;

  // Memory request port
  always_comb begin
    vramWe    = stb.commitWr;
    vramRe    = stb.loadRd | stb.stepRd;
    vramWdata = {busWdata, dataLo};
    if (stb.commitWr) begin
      vramAddr = wAddr[ADDR_W-1:0];
    end else if (stb.loadRd) begin
      vramAddr = rLoadVal[ADDR_W-1:0];
    end else begin
      vramAddr = rStepVal[ADDR_W-1:0];
    end
  end

  // Register file with byte-lane writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wAddr      <= '0;
      rAddr      <= '0;
      dataLo     <= '0;
      irqEn      <= '0;
      strideCode <= '0;
    end else begin
      if (stb.laneLo) begin
        case (stb.target)
          SEL_WADDR: wAddr[7:0] <= busWdata;
          SEL_RADDR: rAddr[7:0] <= busWdata;
          SEL_DATA:  dataLo     <= busWdata;
          SEL_CTRL:  irqEn      <= busWdata[EVT_W-1:0];
          default:   ;
        endcase
      end
      if (stb.laneHi) begin
        case (stb.target)
          SEL_WADDR: wAddr[15:8] <= busWdata;
          SEL_RADDR: rAddr[15:8] <= busWdata;
          SEL_DATA:  wAddr       <= wAddr + stride;
          SEL_CTRL:  strideCode  <= busWdata[4:3];
          default:   ;
        endcase
      end
      if (stb.stepRd) begin
        rAddr <= rStepVal;
      end
    end
  end

  // Prefetch buffer, one cycle behind the request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend  <= 1'b0;
      readBuf <= '0;
    end else begin
      rdPend <= vramRe;
      if (rdPend) begin
        readBuf <= vramRdata;
      end
    end
  end

  // Status: events set, a status read clears, a new event wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statBits <= '0;
    end else begin
      statBits <= (stb.clrStat ? '0 : statBits) | evtIn;
    end
  end

  assign irqOut = |(statBits & irqEn);

  always_comb begin
    case (hostOfs_e'(busAddr))
      OFS_STAT: busRdata = {{PAD_W{1'b0}}, statBits};
      OFS_AUX:  busRdata = (dotClkSel != 2'd0) ? AUX_FAST : '0;
      OFS_LO:   busRdata = readBuf[7:0];
      default:  busRdata = readBuf[15:8];
    endcase
  end

  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrStat && evtIn == '0) |=> statBits == '0); // R3

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrStat && evtIn == '0) |=> !irqOut); // R4

  AST_WADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.commitWr |=> wAddr == $past(wAddr + stride)); // R11

  AST_LANE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.laneLo && stb.target == SEL_CTRL) |=> strideCode == $past(strideCode)); // R2

  AST_ONE_VRAM_OP: assert property (@(posedge clk) disable iff (!rstN)
    !(vramWe && vramRe)); // R11

  AST_LO_READ_NO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.stepRd && !stb.laneLo && !stb.laneHi) |=> $stable(rAddr)); // R6

endmodule

// File: rtl/vid_host_port.sv
module vid_host_port
  import vid_host_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [5:0]        evtIn,
  input  logic [1:0]        dotClkSel,
  output logic              irqOut,
  output logic [ADDR_W-1:0] vramAddr,
  output logic              vramWe,
  output logic [15:0]       vramWdata,
  output logic              vramRe,
  input  logic [15:0]       vramRdata
);

  hostStb_t stb;

  vid_host_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWe      (busWe),
    .busRe      (busRe),
    .busSelByte (busWdata[SEL_W-1:0]),
    .stb        (stb)
  );

  vid_host_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .evtIn     (evtIn),
    .dotClkSel (dotClkSel),
    .irqOut    (irqOut),
    .vramAddr  (vramAddr),
    .vramWe    (vramWe),
    .vramWdata (vramWdata),
    .vramRe    (vramRe),
    .vramRdata (vramRdata)
  );

endmodule

// File: tb/vid_host_port_tb_top.sv
`timescale 1ns/1ps
module vid_host_port_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [5:0]  evtIn = '0;
  logic [1:0]  dotClkSel = '0;
  logic        irqOut;
  logic [14:0] vramAddr;
  logic        vramWe;
  logic [15:0] vramWdata;
  logic        vramRe;
  logic [15:0] rdQ = '0;

  always #2 clk = ~clk;

  vid_host_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .evtIn(evtIn), .dotClkSel(dotClkSel),
    .irqOut(irqOut), .vramAddr(vramAddr), .vramWe(vramWe), .vramWdata(vramWdata),
    .vramRe(vramRe), .vramRdata(rdQ)
  );

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 0;

  logic [15:0] mem [int];
  logic [14:0] lastWA = '0;
  logic [14:0] lastRA = '0;
  logic [15:0] lastWD = '0;
  logic [15:0] expW;
  logic [7:0]  q, qh;
  logic [15:0] words [3];

  function automatic logic [15:0] memInit(input int a);
    return 16'((a * 40503) ^ 23130);
  endfunction

  function automatic logic [15:0] memAt(input logic [14:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return memInit(int'(a));
  endfunction

  function automatic logic [15:0] bStride(input logic [1:0] code);
    case (code)
      2'd0: return 16'd1;
      2'd1: return 16'd32;
      2'd2: return 16'd64;
      default: return 16'd128;
    endcase
  endfunction

  // Video memory model: one-cycle read latency
  always @(posedge clk) begin
    if (vramWe) begin
      mem[int'(vramAddr)] = vramWdata;
      lastWA = vramAddr;
      lastWD = vramWdata;
    end
    if (vramRe) begin
      rdQ <= memAt(vramAddr);
      lastRA = vramAddr;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Tasks start and end at a falling edge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    busAddr = a; busRe = 1'b1;
    #1 v = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic setReg(input logic [4:0] sel, input logic [15:0] w);
    wr(2'd0, {3'b0, sel});
    wr(2'd2, w[7:0]);
    wr(2'd3, w[15:8]);
  endtask

  task automatic setCtrl(input logic [1:0] code, input logic [5:0] en);
    setReg(5'd5, (16'(code) << 11) | 16'(en));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [5:0] e);
    evtIn = e;
    @(negedge clk);
    evtIn = '0;
  endtask

  // Select must already be 2.
  task automatic wrWord(input string tag, input logic [15:0] w, input logic [1:0] code);
    wr(2'd2, w[7:0]);
    wr(2'd3, w[15:8]);
    chk({tag, " addr"}, 16'(lastWA), 16'(expW[14:0]));
    chk({tag, " data"}, lastWD, w);
    expW = expW + bStride(code);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    chkCnt++;
    errCnt++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd2917));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    rd(2'd0, q);  chk("R3 reset status", 16'(q), 16'h00);
    chk("R4 reset irq", 16'(irqOut), 16'h0);
    rd(2'd2, q);  chk("R5 reset buffer", 16'(q), 16'h00);
    rd(2'd1, q);  chk("R9 aux slow", 16'(q), 16'h00);
    dotClkSel = 2'd1; rd(2'd1, q); chk("R9 aux mode1", 16'(q), 16'h40);
    dotClkSel = 2'd3; rd(2'd1, q); chk("R9 aux mode3", 16'(q), 16'h40);
    dotClkSel = 2'd0;

    // Byte lanes, select decode, write path
    setCtrl(2'd0, 6'd0);
    wr(2'd0, 8'd0);
    wr(2'd2, 8'h34); wr(2'd3, 8'h12); wr(2'd2, 8'h56);
    wr(2'd1, 8'h05); // offset 1 write must not move the select
    wr(2'd0, 8'd2);
    wr(2'd2, 8'hCD); wr(2'd3, 8'hAB);
    chk("R2 low lane keeps high", 16'(lastWA), 16'h1256);
    chk("R11 assembled word", lastWD, 16'hABCD);
    chk("R1 offset1 write inert", 16'(lastWA), 16'h1256);
    wr(2'd2, 8'h11); wr(2'd3, 8'h22);
    chk("R11 step after write", 16'(lastWA), 16'h1257);
    wr(2'd0, 8'd0); wr(2'd3, 8'h30);
    wr(2'd0, 8'd2); wr(2'd2, 8'h01); wr(2'd3, 8'h02);
    chk("R2 high lane keeps low", 16'(lastWA), 16'h3058);

    // Each stride code
    expW = 16'h3059;
    for (int c = 0; c < 4; c++) begin
      setCtrl(2'(c), 6'd0);
      wr(2'd0, 8'd2);
      wrWord("R7 stride a", 16'h1000 + 16'(c), 2'(c));
      wrWord("R7 stride b", 16'h2000 + 16'(c), 2'(c));
    end

    // Write address wrap and masking
    setCtrl(2'd0, 6'd0);
    setReg(5'd0, 16'hFFFF);
    wr(2'd0, 8'd2);
    wr(2'd2, 8'h44); wr(2'd3, 8'h33);
    chk("R8 mask 0xFFFF", 16'(lastWA), 16'h7FFF);
    wr(2'd2, 8'h66); wr(2'd3, 8'h55);
    chk("R8 wrap to zero", 16'(lastWA), 16'h0000);

    // Read path and latency
    setReg(5'd1, 16'h4000);
    chk("R10 prefetch address", 16'(lastRA), 16'h4000);
    idle(1);
    wr(2'd0, 8'd2);
    rd(2'd2, q);  chk("R10 prefetched low", 16'(q), 16'(memAt(15'h4000) & 16'h00FF));
    rd(2'd2, q);  chk("R6 low read no step", 16'(lastRA), 16'h4000);
    rd(2'd3, qh); chk("R5 high byte", 16'(qh), 16'(memAt(15'h4000) >> 8));
    chk("R6 step on high read", 16'(lastRA), 16'h4001);
    rd(2'd2, q);  chk("R12 old buffer in gap", 16'(q), 16'(memAt(15'h4000) & 16'h00FF));
    rd(2'd2, q);  chk("R12 new buffer after", 16'(q), 16'(memAt(15'h4001) & 16'h00FF));
    setCtrl(2'd3, 6'd0);
    setReg(5'd1, 16'hFFC0);
    chk("R8 read mask", 16'(lastRA), 16'h7FC0);
    idle(1);
    wr(2'd0, 8'd2);
    rd(2'd3, qh);
    chk("R8 read wrap", 16'(lastRA), 16'h0040);

    // Status and interrupt
    setCtrl(2'd0, 6'h05);
    pulse(6'h01); chk("R4 irq on enabled event", 16'(irqOut), 16'h1);
    pulse(6'h02);
    rd(2'd0, q);  chk("R3 status value", 16'(q), 16'h03);
    chk("R4 irq cleared", 16'(irqOut), 16'h0);
    rd(2'd0, q);  chk("R3 status cleared", 16'(q), 16'h00);
    pulse(6'h02); chk("R4 masked event", 16'(irqOut), 16'h0);
    evtIn = 6'h04;
    rd(2'd0, q);
    evtIn = '0;
    chk("R3 same-cycle event excluded", 16'(q), 16'h02);
    chk("R4 same-cycle event keeps irq", 16'(irqOut), 16'h1);
    rd(2'd0, q);  chk("R3 same-cycle event kept", 16'(q), 16'h04);
    chk("R4 irq low after", 16'(irqOut), 16'h0);

    // Random write-then-read rounds
    for (int it = 0; it < 25; it++) begin
      logic [1:0]  code;
      logic [15:0] wa;
      code = 2'($urandom % 4);
      wa = 16'($urandom);
      setCtrl(code, 6'd0);
      setReg(5'd0, wa);
      expW = wa;
      wr(2'd0, 8'd2);
      for (int k = 0; k < 3; k++) begin
        words[k] = 16'($urandom);
        wrWord("R11 random", words[k], code);
      end
      setReg(5'd1, wa);
      idle(1);
      wr(2'd0, 8'd2);
      for (int k = 0; k < 3; k++) begin
        rd(2'd2, q);
        rd(2'd3, qh);
        chk("R6 random readback", {qh, q}, words[k]);
        idle(1);
      end
    end

    summary();
  end

endmodule